// File: doc/BRIEF.md
# Remote DMA Controller With Abort

This block moves data between a host-facing data port and a local packet memory under the control of a small byte-wide register port. Software loads a 16-bit memory address and a 16-bit byte count, picks the transfer width and host byte order, and then writes a command. A write command takes data words from the host and stores them in memory. A read or send command fetches memory ahead of the host and presents each word on the host port with a data-ready flag.

The address and count are single live registers. Each transfer moves the address up and the count down. The host can read both at any time, including while a transfer runs. When the count runs out, a sticky completion flag is set, and the host clears it by writing a one to it. An abort command stops a transfer at once. The address and count then keep the values they had reached, so software clears the count itself.

Top module: `rdma_ctrl`

## Requirements
- R1: After reset the block is idle. Address, count, configuration and completion flag read as zero. mem_req, host_wr_ready and host_rd_valid are low.
- R2: Command register offset 0 decodes wdata[2:0] as follows: 001 is read, 011 is send (same behaviour as read), 010 is write, and any value with bit 2 set is abort. 000 is ignored and changes no state. Reading offset 0 returns the busy flag in bit 0. The block never offers write data acceptance and read data at the same time.
- R3: In a write transfer, each accepted host word produces one memory write at the live address in the same cycle. Offsets 1/2 (address low/high) then advance by the step and offsets 3/4 (count low/high) fall by the step. The step is 1 in byte mode and 2 in word mode. In byte mode only the low host byte is used, on lane [7:0] with mem_size=0.
- R4: A read transfer fetches memory before the host asks. It raises host_rd_valid and holds host_rd_data steady until host_rd_ready takes the word. The address and count advance on each take.
- R5: In word mode, a remaining count of 1 still moves one full word. The count then becomes 0 and the transfer completes.
- R6: Configuration offset 5: bit 0 selects word mode, bit 1 selects big-endian host order. With big-endian order in word mode, host bits [15:8] map to the byte at the lower memory address. With little-endian order they map to the higher address. Memory lane [7:0] is always the lower address.
- R7: Status offset 6 bit 0 is set when a transfer completes. It stays set until a write to offset 6 with bit 0 equal to 1. Writing 0 leaves it set.
- R8: An abort stops the transfer in the cycle it is written. There is no further memory access or host handshake. The address and count keep their advanced values, and completion is not flagged.
- R9: While busy, commands other than abort, and writes to address, count or configuration, are ignored.
- R10: A read or write command issued with a count of zero completes at once with no memory access, and sets the completion flag.
- R11: The live address and count are readable through offsets 1 to 4 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| host_wr_valid | input | 1 | Host offers a write word |
| host_wr_data | input | 2*REG_W | Host write word |
| host_wr_ready | output | 1 | Block accepts the host write word |
| host_rd_valid | output | 1 | Read word is ready |
| host_rd_data | output | 2*REG_W | Read word |
| host_rd_ready | input | 1 | Host takes the read word |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 1 | 1 for a two-byte access, 0 for one byte |
| mem_addr | output | 2*REG_W | Byte address of the access |
| mem_wdata | output | 2*REG_W | Write lanes, [7:0] at mem_addr |
| mem_rdata | input | 2*REG_W | Read lanes, one cycle after the request |

## Verification
The bench builds the block with its default parameters: byte-wide registers, 16-bit addresses and counts, and a 3-bit register offset. The attached memory model decodes only the low address byte. With these values, short counts are enough to reach several cases in a few dozen cycles: byte and word steps, an odd tail in word mode, both host byte orders, a zero-length command, and an abort in the middle of a write.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_FETCH = 3'd2,
    ST_CAPT  = 3'd3,
    ST_HOLD  = 3'd4
  } rdma_state_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ABORT = 2'd3
  } rdma_op_e;

  localparam int OFS_CMD  = 0;
  localparam int OFS_ALO  = 1;
  localparam int OFS_AHI  = 2;
  localparam int OFS_CLO  = 3;
  localparam int OFS_CHI  = 4;
  localparam int OFS_CFG  = 5;
  localparam int OFS_STAT = 6;

  // bit 2 forces abort; 001 and 011 both read memory toward the host
  function automatic rdma_op_e decode_cmd(input logic [2:0] c);
    rdma_op_e r;
    if (c[2]) begin
      r = OP_ABORT;
    end else begin
      unique case (c[1:0])
        2'b01, 2'b11: r = OP_READ;
        2'b10:        r = OP_WRITE;
        default:      r = OP_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rdma_ptr.sv
`timescale 1ns/1ps
// Live pointer: byte-loadable, steps up (address) or down with floor at zero (count)
module rdma_ptr #(
  parameter int REG_W = 8,
  parameter bit DOWN  = 1'b0,
  localparam int AW   = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [REG_W-1:0] ld_data,
  input  logic             step_en,
  input  logic [AW-1:0]    step,
  output logic [AW-1:0]    value,
  output logic             last
);

  logic [AW-1:0] val_q, val_d, stepped;
  logic          val_en;

  generate
    if (DOWN) begin : g_down
      assign stepped = (val_q <= step) ? '0 : (val_q - step);
    end else begin : g_up
      assign stepped = val_q + step;
    end
  endgenerate

  always_comb begin
    val_d = val_q;
    if (ld_lo) val_d[REG_W-1:0]  = ld_data;
    if (ld_hi) val_d[AW-1:REG_W] = ld_data;
    if (step_en) val_d = stepped;
    val_en = ld_lo | ld_hi | step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign value = val_q;
  assign last  = (val_q <= step);

endmodule

// File: rtl/rdma_lanes.sv
`timescale 1ns/1ps
// Byte lane steering between host order and memory order
module rdma_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DW    = LANE_W * LANES
) (
  input  logic [DW-1:0] din,
  input  logic          swap,
  input  logic          narrow,
  output logic [DW-1:0] dout
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_low
        assign dout[LANE_W-1:0] = (swap && !narrow)
                                  ? din[(LANES-1)*LANE_W +: LANE_W]
                                  : din[LANE_W-1:0];
      end else begin : g_high
        assign dout[i*LANE_W +: LANE_W] = narrow ? '0
                                        : swap ? din[(LANES-1-i)*LANE_W +: LANE_W]
                                               : din[i*LANE_W +: LANE_W];
      end
    end
  endgenerate

endmodule

// File: rtl/rdma_regfile.sv
`timescale 1ns/1ps
module rdma_regfile
  import rdma_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int RA_W  = 3,
  localparam int AW   = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic             set_done,
  input  logic [AW-1:0]    cur_addr,
  input  logic [AW-1:0]    cur_cnt,
  output rdma_op_e         op,
  output logic             addr_ld_lo,
  output logic             addr_ld_hi,
  output logic             cnt_ld_lo,
  output logic             cnt_ld_hi,
  output logic             cfg_word,
  output logic             cfg_be,
  output logic             done
);

  logic     sel_cmd, sel_alo, sel_ahi, sel_clo, sel_chi, sel_cfg, sel_stat;
  rdma_op_e cmd_op;
  logic     cfg_en, cfg_word_d, cfg_be_d, cfg_word_q, cfg_be_q;
  logic     done_en, done_d, done_q;
  logic     unused_wbits;

  assign sel_cmd  = reg_wr && (reg_addr == RA_W'(OFS_CMD));
  assign sel_alo  = reg_wr && (reg_addr == RA_W'(OFS_ALO));
  assign sel_ahi  = reg_wr && (reg_addr == RA_W'(OFS_AHI));
  assign sel_clo  = reg_wr && (reg_addr == RA_W'(OFS_CLO));
  assign sel_chi  = reg_wr && (reg_addr == RA_W'(OFS_CHI));
  assign sel_cfg  = reg_wr && (reg_addr == RA_W'(OFS_CFG));
  assign sel_stat = reg_wr && (reg_addr == RA_W'(OFS_STAT));

  assign cmd_op = decode_cmd(reg_wdata[2:0]);
  // while busy only abort gets through
  assign op = !sel_cmd ? OP_NONE
            : (busy && (cmd_op != OP_ABORT)) ? OP_NONE : cmd_op;

  assign addr_ld_lo = sel_alo && !busy;
  assign addr_ld_hi = sel_ahi && !busy;
  assign cnt_ld_lo  = sel_clo && !busy;
  assign cnt_ld_hi  = sel_chi && !busy;

  always_comb begin
    cfg_en     = sel_cfg && !busy;
    cfg_word_d = reg_wdata[0];
    cfg_be_d   = reg_wdata[1];
    done_en    = set_done || (sel_stat && reg_wdata[0]);
    done_d     = set_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word_q <= 1'b0;
      cfg_be_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (cfg_en) begin
        cfg_word_q <= cfg_word_d;
        cfg_be_q   <= cfg_be_d;
      end
      if (done_en) done_q <= done_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_W'(OFS_CMD):  reg_rdata = REG_W'(busy);
      RA_W'(OFS_ALO):  reg_rdata = cur_addr[REG_W-1:0];
      RA_W'(OFS_AHI):  reg_rdata = cur_addr[AW-1:REG_W];
      RA_W'(OFS_CLO):  reg_rdata = cur_cnt[REG_W-1:0];
      RA_W'(OFS_CHI):  reg_rdata = cur_cnt[AW-1:REG_W];
      RA_W'(OFS_CFG):  reg_rdata = REG_W'({cfg_be_q, cfg_word_q});
      RA_W'(OFS_STAT): reg_rdata = REG_W'(done_q);
      default:         reg_rdata = '0;
    endcase
  end

  assign unused_wbits = ^reg_wdata[REG_W-1:3];
  assign cfg_word = cfg_word_q;
  assign cfg_be   = cfg_be_q;
  assign done     = done_q;

endmodule

// File: rtl/rdma_ctrl.sv
`timescale 1ns/1ps
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int RA_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               host_wr_valid,
  input  logic [2*REG_W-1:0] host_wr_data,
  output logic               host_wr_ready,
  output logic               host_rd_valid,
  output logic [2*REG_W-1:0] host_rd_data,
  input  logic               host_rd_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_size,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_wdata,
  input  logic [2*REG_W-1:0] mem_rdata
);

  localparam int AW    = 2 * REG_W;
  localparam int HW    = 2 * REG_W;
  localparam int LANES = HW / REG_W;

  rdma_state_e   state_q, state_d;
  rdma_op_e      op;
  logic          busy, done, set_done;
  logic          cfg_word, cfg_be;
  logic          addr_ld_lo, addr_ld_hi, cnt_ld_lo, cnt_ld_hi;
  logic [AW-1:0] cur_addr, cur_cnt, step;
  logic          cnt_last, cnt_zero, unused_addr_last;
  logic          abort_now, wr_fire, rd_fire, step_en;
  logic [HW-1:0] rd_lanes, rd_buf_q;
  logic          rd_buf_en;

  assign busy = (state_q != ST_IDLE);

  rdma_regfile #(.REG_W(REG_W), .RA_W(RA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .set_done   (set_done),
    .cur_addr   (cur_addr),
    .cur_cnt    (cur_cnt),
    .op         (op),
    .addr_ld_lo (addr_ld_lo),
    .addr_ld_hi (addr_ld_hi),
    .cnt_ld_lo  (cnt_ld_lo),
    .cnt_ld_hi  (cnt_ld_hi),
    .cfg_word   (cfg_word),
    .cfg_be     (cfg_be),
    .done       (done)
  );

  assign step      = {{(AW-2){1'b0}}, cfg_word, ~cfg_word};
  assign abort_now = (op == OP_ABORT);
  assign cnt_zero  = (cur_cnt == '0);

  assign host_wr_ready = (state_q == ST_WRITE) && !abort_now;
  assign host_rd_valid = (state_q == ST_HOLD) && !abort_now;
  assign wr_fire       = host_wr_ready && host_wr_valid;
  assign rd_fire       = host_rd_valid && host_rd_ready;
  assign step_en       = wr_fire || rd_fire;

  rdma_ptr #(.REG_W(REG_W), .DOWN(1'b0)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (addr_ld_lo),
    .ld_hi   (addr_ld_hi),
    .ld_data (reg_wdata),
    .step_en (step_en),
    .step    (step),
    .value   (cur_addr),
    .last    (unused_addr_last)
  );

  rdma_ptr #(.REG_W(REG_W), .DOWN(1'b1)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (cnt_ld_lo),
    .ld_hi   (cnt_ld_hi),
    .ld_data (reg_wdata),
    .step_en (step_en),
    .step    (step),
    .value   (cur_cnt),
    .last    (cnt_last)
  );

  rdma_lanes #(.LANE_W(REG_W), .LANES(LANES)) u_wr_lanes (
    .din    (host_wr_data),
    .swap   (cfg_be),
    .narrow (~cfg_word),
    .dout   (mem_wdata)
  );

  rdma_lanes #(.LANE_W(REG_W), .LANES(LANES)) u_rd_lanes (
    .din    (mem_rdata),
    .swap   (cfg_be),
    .narrow (~cfg_word),
    .dout   (rd_lanes)
  );

  assign mem_req  = wr_fire || ((state_q == ST_FETCH) && !abort_now);
  assign mem_we   = wr_fire;
  assign mem_size = cfg_word;
  assign mem_addr = cur_addr;

  always_comb begin
    state_d  = state_q;
    set_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (op == OP_READ) begin
          if (cnt_zero) set_done = 1'b1;
          else          state_d  = ST_FETCH;
        end else if (op == OP_WRITE) begin
          if (cnt_zero) set_done = 1'b1;
          else          state_d  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (abort_now) begin
          state_d = ST_IDLE;
        end else if (wr_fire && cnt_last) begin
          state_d  = ST_IDLE;
          set_done = 1'b1;
        end
      end
      ST_FETCH: state_d = abort_now ? ST_IDLE : ST_CAPT;
      ST_CAPT:  state_d = abort_now ? ST_IDLE : ST_HOLD;
      ST_HOLD: begin
        if (abort_now) begin
          state_d = ST_IDLE;
        end else if (rd_fire) begin
          if (cnt_last) begin
            state_d  = ST_IDLE;
            set_done = 1'b1;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rd_buf_en = (state_q == ST_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_buf_q <= '0;
    end else begin
      state_q <= state_d;
      if (rd_buf_en) rd_buf_q <= rd_lanes;
    end
  end

  assign host_rd_data = rd_buf_q;

endmodule

// File: rtl/rdma_ctrl_chk.sv
`timescale 1ns/1ps
module rdma_ctrl_chk #(
  parameter int REG_W = 8,
  parameter int RA_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [RA_W-1:0]    reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic               host_wr_valid,
  input logic               host_wr_ready,
  input logic               host_rd_valid,
  input logic               host_rd_ready,
  input logic [2*REG_W-1:0] host_rd_data,
  input logic               mem_req,
  input logic               mem_we,
  input logic               busy,
  input logic               done,
  input logic               cfg_word,
  input logic [2*REG_W-1:0] cur_addr,
  input logic [2*REG_W-1:0] cur_cnt
);

  logic cmd_wr, abort_wr, clr_wr;
  assign cmd_wr   = reg_wr && (reg_addr == RA_W'(0));
  assign abort_wr = cmd_wr && reg_wdata[2];
  assign clr_wr   = reg_wr && (reg_addr == RA_W'(6)) && reg_wdata[0];

  p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_ready && host_rd_valid));

  p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && (reg_wdata[2:0] == 3'b000))
    |=> (!busy && $stable(cur_addr) && $stable(cur_cnt)));

  p_write_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && host_wr_ready) |-> (mem_req && mem_we));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_valid && !host_rd_ready) |=> $stable(host_rd_data));

  p_odd_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word && (cur_cnt == 1) && host_wr_valid && host_wr_ready)
    |=> ((cur_cnt == 0) && done && !busy));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_wr) |=> done);

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!mem_req && !host_wr_ready && !host_rd_valid));

  p_abort_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> ($stable(cur_addr) && $stable(cur_cnt)));

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !reg_wdata[2] && (reg_wdata[1:0] != 2'b00) && (cur_cnt == 0))
    |=> (done && !busy));

endmodule

bind rdma_ctrl rdma_ctrl_chk #(.REG_W(REG_W), .RA_W(RA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .host_wr_valid (host_wr_valid),
  .host_wr_ready (host_wr_ready),
  .host_rd_valid (host_rd_valid),
  .host_rd_ready (host_rd_ready),
  .host_rd_data  (host_rd_data),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .busy          (busy),
  .done          (done),
  .cfg_word      (cfg_word),
  .cur_addr      (cur_addr),
  .cur_cnt       (cur_cnt)
);

// File: tb/sim_rdma_ctrl.sv
`timescale 1ns/1ps
module sim_rdma_ctrl;

  localparam int RW = 8;
  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          host_wr_valid = 1'b0;
  logic [HW-1:0] host_wr_data = '0;
  logic          host_wr_ready;
  logic          host_rd_valid;
  logic [HW-1:0] host_rd_data;
  logic          host_rd_ready = 1'b0;
  logic          mem_req, mem_we, mem_size;
  logic [HW-1:0] mem_addr, mem_wdata;
  logic [HW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  rdma_ctrl #(.REG_W(RW), .RA_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .host_rd_valid(host_rd_valid),
    .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: 256 bytes, lane [7:0] at the lower address, one-cycle read
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_size) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  int mem_acc = 0;

  logic [32:0] exp_mem[$];
  string       exp_mem_tag[$];
  logic [15:0] exp_rd[$];
  string       exp_rd_tag[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: sample between negedge and posedge, pop expected items
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mem_req) mem_acc++;
      if (mem_req && mem_we) begin
        if (exp_mem.size() == 0) begin
          check("R3 unexpected write", {15'd0, mem_size, mem_wdata}, 32'hFFFF_FFFF);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_mem.pop_front();
          t = exp_mem_tag.pop_front();
          check(t, {15'd0, mem_size, mem_addr, mem_wdata}, {15'd0, e});
        end
      end
      if (host_rd_valid && host_rd_ready) begin
        if (exp_rd.size() == 0) begin
          check("R4 unexpected read", {16'd0, host_rd_data}, 32'hFFFF_FFFF);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_rd.pop_front();
          t = exp_rd_tag.pop_front();
          check(t, {16'd0, host_rd_data}, {16'd0, e});
        end
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic read16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    reg_read(lo, l);
    reg_read(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cfg);
    reg_write(3'd5, cfg);
    reg_write(3'd1, a[7:0]);
    reg_write(3'd2, a[15:8]);
    reg_write(3'd3, n[7:0]);
    reg_write(3'd4, n[15:8]);
  endtask

  // driver: queue the expected memory write, then offer the host word
  task automatic host_push(input logic [15:0] d, input logic [32:0] e, input string tag);
    exp_mem.push_back(e);
    exp_mem_tag.push_back(tag);
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_data = d;
    #1;
    while (!host_wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic host_pull(input logic [15:0] e, input string tag);
    exp_rd.push_back(e);
    exp_rd_tag.push_back(tag);
    @(negedge clk);
    host_rd_ready = 1'b1;
    #1;
    while (!host_rd_valid) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    host_rd_ready = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  v8;
    logic [15:0] v16;
    int          acc0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 wr_ready", {31'd0, host_wr_ready}, 32'd0);
    check("R1 rd_valid", {31'd0, host_rd_valid}, 32'd0);
    read16(3'd1, v16); check("R1 address", {16'd0, v16}, 32'd0);
    read16(3'd3, v16); check("R1 count", {16'd0, v16}, 32'd0);
    reg_read(3'd5, v8); check("R1 config", {24'd0, v8}, 32'd0);
    reg_read(3'd6, v8); check("R1 done", {24'd0, v8}, 32'd0);

    // R3 byte-mode write, high host byte dropped
    setup(16'h0010, 16'd3, 8'h00);
    reg_write(3'd0, 8'h02);
    host_push(16'hEE31, {1'b0, 16'h0010, 16'h0031}, "R3 byte write 0");
    host_push(16'hEE32, {1'b0, 16'h0011, 16'h0032}, "R3 byte write 1");
    host_push(16'hEE33, {1'b0, 16'h0012, 16'h0033}, "R3 byte write 2");
    read16(3'd1, v16); check("R3 end address", {16'd0, v16}, 32'h0013);
    read16(3'd3, v16); check("R3 end count", {16'd0, v16}, 32'd0);

    // R7 sticky completion, write-1-to-clear
    reg_read(3'd6, v8); check("R7 done set", {24'd0, v8}, 32'd1);
    reg_write(3'd6, 8'h00);
    reg_read(3'd6, v8); check("R7 write 0 keeps", {24'd0, v8}, 32'd1);
    reg_write(3'd6, 8'h01);
    reg_read(3'd6, v8); check("R7 write 1 clears", {24'd0, v8}, 32'd0);

    // R6 word write little-endian, step 2
    setup(16'h0020, 16'd4, 8'h01);
    reg_write(3'd0, 8'h02);
    host_push(16'hBBAA, {1'b1, 16'h0020, 16'hBBAA}, "R6 word LE 0");
    host_push(16'hDDCC, {1'b1, 16'h0022, 16'hDDCC}, "R6 word LE 1");
    read16(3'd1, v16); check("R3 word step address", {16'd0, v16}, 32'h0024);
    reg_write(3'd6, 8'h01);

    // R6 word write big-endian swaps lanes
    setup(16'h0030, 16'd2, 8'h03);
    reg_write(3'd0, 8'h02);
    host_push(16'h1234, {1'b1, 16'h0030, 16'h3412}, "R6 word BE write");
    reg_write(3'd6, 8'h01);

    // R4 R5 R6 R11 word read big-endian with odd count 3
    setup(16'h0020, 16'd3, 8'h03);
    reg_write(3'd0, 8'h01);
    reg_read(3'd0, v8); check("R2 busy during read", {24'd0, v8}, 32'd1);
    host_pull(16'hAABB, "R4 R6 read word 0");
    read16(3'd1, v16); check("R11 live address", {16'd0, v16}, 32'h0022);
    read16(3'd3, v16); check("R11 live count", {16'd0, v16}, 32'd1);
    host_pull(16'hCCDD, "R5 odd tail word");
    read16(3'd1, v16); check("R5 end address", {16'd0, v16}, 32'h0024);
    read16(3'd3, v16); check("R5 end count", {16'd0, v16}, 32'd0);
    reg_read(3'd6, v8); check("R5 done", {24'd0, v8}, 32'd1);
    reg_write(3'd6, 8'h01);

    // R2 send command reads like read, byte mode zero-extends
    setup(16'h0010, 16'd2, 8'h00);
    reg_write(3'd0, 8'h03);
    host_pull(16'h0031, "R2 send byte 0");
    host_pull(16'h0032, "R2 send byte 1");
    reg_read(3'd6, v8); check("R2 send done", {24'd0, v8}, 32'd1);
    reg_write(3'd6, 8'h01);

    // R2 illegal command 000 ignored
    setup(16'h0055, 16'd7, 8'h00);
    acc0 = mem_acc;
    reg_write(3'd0, 8'h00);
    reg_read(3'd0, v8); check("R2 illegal not busy", {24'd0, v8}, 32'd0);
    read16(3'd1, v16); check("R2 illegal address", {16'd0, v16}, 32'h0055);
    read16(3'd3, v16); check("R2 illegal count", {16'd0, v16}, 32'd7);
    check("R2 illegal no access", mem_acc, acc0);

    // R9 R8 busy lockout then abort mid-write
    setup(16'h0040, 16'd4, 8'h00);
    reg_write(3'd0, 8'h02);
    host_push(16'h0011, {1'b0, 16'h0040, 16'h0011}, "R8 pre-abort 0");
    host_push(16'h0022, {1'b0, 16'h0041, 16'h0022}, "R8 pre-abort 1");
    reg_write(3'd1, 8'h99);
    reg_write(3'd5, 8'h01);
    reg_write(3'd0, 8'h01);
    @(negedge clk); #1;
    check("R9 still write mode", {31'd0, host_wr_ready}, 32'd1);
    reg_read(3'd5, v8); check("R9 config locked", {24'd0, v8}, 32'd0);
    reg_write(3'd0, 8'h04);
    acc0 = mem_acc;
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_data = 16'h0077;
    repeat (3) @(negedge clk);
    #1;
    check("R8 ready low", {31'd0, host_wr_ready}, 32'd0);
    host_wr_valid = 1'b0;
    check("R8 no access", mem_acc, acc0);
    read16(3'd1, v16); check("R8 address kept", {16'd0, v16}, 32'h0042);
    read16(3'd3, v16); check("R8 count kept", {16'd0, v16}, 32'd2);
    reg_read(3'd6, v8); check("R8 no done", {24'd0, v8}, 32'd0);
    reg_write(3'd3, 8'h00);
    reg_write(3'd4, 8'h00);

    // R10 zero count completes at once
    acc0 = mem_acc;
    reg_write(3'd0, 8'h02);
    reg_read(3'd6, v8); check("R10 done", {24'd0, v8}, 32'd1);
    reg_read(3'd0, v8); check("R10 idle", {24'd0, v8}, 32'd0);
    check("R10 no access", mem_acc, acc0);
    check("R10 ready low", {31'd0, host_wr_ready}, 32'd0);

    check("R3 memory byte", {24'd0, mem[8'h21]}, 32'h00BB);
    check("R4 queues drained", exp_mem.size() + exp_rd.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule